// File: doc/BRIEF.md
# Branch Colour Stream Filter

This block sits between an instruction prefetch pipeline and the decode stage. It removes wrong-path instructions after a taken branch without a global flush. The fetch unit stamps every packet with a small colour tag, and each packet carries its own program counter. The filter keeps the colour that the execute side currently expects. A packet whose tag matches goes through to decode under a normal valid/ready handshake. A packet whose tag differs is accepted and thrown away, so the upstream queue keeps draining however many stale packets it holds.

A taken branch moves the expected colour on by one, modulo 2^COLOUR_W. It also queues a new-stream request that carries the branch target. The fetch side sees a pending request as `req_valid`/`req_target` and takes it with a one-cycle `req_ack`. On each request it accepts, the fetch side moves its own stamping colour on by one. Up to 2^COLOUR_W-1 requests can wait in order, so every stale colour still differs from the current one. The reset input is asynchronous and active low, and its release passes through a two-stage synchroniser.

Top module: `stream_colour_filter`

## Requirements
- R1: While reset is released, no request is pending (`req_valid`=0) and the expected colour is 0, so a packet tagged 0 is passed.
- R2: When `in_colour` equals the expected colour, `out_valid`=`in_valid`, `in_ready`=`out_ready`, and `out_pc`/`out_insn` equal `in_pc`/`in_insn` in the same cycle.
- R3: When `in_colour` differs from the expected colour, `out_valid`=0 and `in_ready`=1 whatever `out_ready` is, so the packet is consumed and dropped.
- R4: A cycle with `br_taken`=1 raises the expected colour by 1 from the next cycle on. Packets tagged with the old colour are dropped in any number until a packet with the new colour arrives.
- R5: In the cycle after a `br_taken` strobe, `req_valid` is 1. If the request queue was empty, `req_target` then equals that strobe's `br_target`.
- R6: A pending request keeps `req_valid`=1 and an unchanged `req_target` in every cycle until it is acknowledged. `req_ack`=1 while `req_valid`=1 removes it at that clock edge.
- R7: Up to 2^COLOUR_W-1 branches can be pending. They are presented to fetch one at a time, oldest first. A branch and an acknowledge in the same cycle both take effect.
- R8: The expected colour wraps from 2^COLOUR_W-1 to 0, so after 2^COLOUR_W branches, packets tagged 0 pass again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_taken | input | 1 | Taken-branch strobe from execute, one cycle per branch |
| br_target | input | AW | Target address of the taken branch |
| req_valid | output | 1 | A new-stream request is pending for fetch |
| req_target | output | AW | Target address of the oldest pending request |
| req_ack | input | 1 | Fetch takes the pending request |
| in_valid | input | 1 | Prefetched packet present |
| in_ready | output | 1 | Packet consumed this cycle (passed or dropped) |
| in_colour | input | COLOUR_W | Colour tag stamped by fetch |
| in_pc | input | AW | Program counter of the packet |
| in_insn | input | DW | Instruction word of the packet |
| out_valid | output | 1 | Packet offered to decode |
| out_ready | input | 1 | Decode accepts the packet |
| out_pc | output | AW | Program counter forwarded to decode |
| out_insn | output | DW | Instruction forwarded to decode |

## Verification
A wrong expected colour is visible in the very next cycle: every tag value is swept against it, and the pass/drop pattern on `out_valid` and `in_ready` would show the wrong value at once. A corrupt request queue shows on `req_valid`/`req_target` once the branch strobe has settled. With back-to-back branches the queue is drained and its order compared against the branch sequence, so a lost, repeated or reordered target is caught at the acknowledge where it appears. The wrap of the colour counter is driven through all of its values, including a branch and an acknowledge landing in the same cycle.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  typedef enum logic {
    PKT_DROP = 1'b0,
    PKT_PASS = 1'b1
  } pkt_verdict_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/sbf_colour_reg.sv
module sbf_colour_reg #(
  parameter int COLOUR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  output logic [COLOUR_W-1:0] colour
);
  logic [COLOUR_W-1:0] colour_q;
  logic [COLOUR_W-1:0] colour_d;

  always_comb begin
    colour_d = colour_q + COLOUR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colour_q <= '0;
    end else if (advance) begin
      colour_q <= colour_d;
    end
  end

  assign colour = colour_q;
endmodule

// File: rtl/sbf_req_queue.sv
module sbf_req_queue #(
  parameter int AW    = 32,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic          valid,
  output logic          full,
  output logic [AW-1:0] head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop_en;

  assign valid  = (cnt_q != '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign pop_en = pop && valid;
  assign head   = slot_q[rd_q];

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_d  = push   ? ptr_inc(wr_q) : wr_q;
    rd_d  = pop_en ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push && !pop_en) cnt_d = cnt_q + CW'(1);
    if (!push && pop_en) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wr_q == PW'(i));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[i] <= push_addr;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !pop) |=> (valid && head == $past(head)));
endmodule

// File: rtl/sbf_pass_gate.sv
module sbf_pass_gate
  import sbf_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int COLOUR_W = 2
) (
  input  logic [COLOUR_W-1:0] expect_colour,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [COLOUR_W-1:0] in_colour,
  input  logic [AW-1:0]       in_pc,
  input  logic [DW-1:0]       in_insn,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [AW-1:0]       out_pc,
  output logic [DW-1:0]       out_insn
);
  pkt_verdict_e verdict;

  always_comb begin
    verdict   = (in_colour == expect_colour) ? PKT_PASS : PKT_DROP;
    out_valid = in_valid && (verdict == PKT_PASS);
    in_ready  = (verdict == PKT_PASS) ? out_ready : 1'b1;
    out_pc    = in_pc;
    out_insn  = in_insn;
  end
endmodule

// File: rtl/stream_colour_filter.sv
module stream_colour_filter
  import sbf_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int COLOUR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                br_taken,
  input  logic [AW-1:0]       br_target,
  output logic                req_valid,
  output logic [AW-1:0]       req_target,
  input  logic                req_ack,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [COLOUR_W-1:0] in_colour,
  input  logic [AW-1:0]       in_pc,
  input  logic [DW-1:0]       in_insn,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [AW-1:0]       out_pc,
  output logic [DW-1:0]       out_insn
);
  localparam int REQ_DEPTH = (1 << COLOUR_W) - 1;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_ns;
  logic [COLOUR_W-1:0]    cur_colour;
  logic                   req_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_ns = rst_pipe_q[SYNC_STAGES-1];

  sbf_colour_reg #(.COLOUR_W(COLOUR_W)) colour_i (
    .clk     (clk),
    .rst_n   (rst_ns),
    .advance (br_taken),
    .colour  (cur_colour)
  );

  sbf_req_queue #(.AW(AW), .DEPTH(REQ_DEPTH)) reqq_i (
    .clk       (clk),
    .rst_n     (rst_ns),
    .push      (br_taken),
    .push_addr (br_target),
    .pop       (req_ack),
    .valid     (req_valid),
    .full      (req_full),
    .head      (req_target)
  );

  sbf_pass_gate #(.AW(AW), .DW(DW), .COLOUR_W(COLOUR_W)) gate_i (
    .expect_colour (cur_colour),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_colour     (in_colour),
    .in_pc         (in_pc),
    .in_insn       (in_insn),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_pc        (out_pc),
    .out_insn      (out_insn)
  );

  // R3
  drop_accept_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_valid && in_colour != cur_colour) |-> (in_ready && !out_valid));

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_valid && in_colour == cur_colour) |-> (out_valid && in_ready == out_ready && out_pc == in_pc));

  // R4
  colour_step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    br_taken |=> (cur_colour == COLOUR_W'($past(cur_colour) + 1'b1)));

  // R5
  req_raise_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    br_taken |=> req_valid);

  // R4
  colour_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !br_taken |=> $stable(cur_colour));

  // R7
  queue_room_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (br_taken && req_full) |-> req_ack);
endmodule

// File: tb/stream_colour_filter_tb.sv
module stream_colour_filter_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          br_taken, req_valid, req_ack;
  logic [AW-1:0] br_target, req_target;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [CW-1:0] in_colour;
  logic [AW-1:0] in_pc, out_pc;
  logic [DW-1:0] in_insn, out_insn;

  int            n_checks = 0;
  int            n_err = 0;
  bit            done = 1'b0;
  logic [CW-1:0] exp_col;
  logic [AW-1:0] mq [$];

  always #5 clk = ~clk;

  stream_colour_filter #(.AW(AW), .DW(DW), .COLOUR_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .br_taken(br_taken), .br_target(br_target),
    .req_valid(req_valid), .req_target(req_target), .req_ack(req_ack),
    .in_valid(in_valid), .in_ready(in_ready), .in_colour(in_colour),
    .in_pc(in_pc), .in_insn(in_insn),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pc(out_pc), .out_insn(out_insn)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_pkt(input int c, input bit v, input bit r);
    @(negedge clk);
    in_colour = CW'(c);
    in_valid  = v;
    out_ready = r;
    in_pc     = AW'(8'h40 + c * 4);
    in_insn   = DW'(c * 16 + 32'(v) * 2 + 32'(r) + 3);
    #1;
  endtask

  task automatic sweep();
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 2; v++) begin
        for (int r = 0; r < 2; r++) begin
          bit match;
          drive_pkt(c, v[0], r[0]);
          match = (CW'(c) == exp_col);
          if (match) begin
            check("R2", "out_valid", int'(out_valid), v);
            check("R2", "in_ready", int'(in_ready), r);
            check("R2", "out_pc", int'(out_pc), int'(in_pc));
            check("R2", "out_insn", int'(out_insn), int'(in_insn));
          end else begin
            check("R3", "out_valid", int'(out_valid), 0);
            check("R3", "in_ready", int'(in_ready), 1);
          end
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_req(input string req);
    check(req, "req_valid", int'(req_valid), int'(mq.size() != 0));
    if (mq.size() != 0) check(req, "req_target", int'(req_target), int'(mq[0]));
  endtask

  task automatic do_branch(input logic [AW-1:0] t, input bit ack_too);
    @(negedge clk);
    br_taken  = 1'b1;
    br_target = t;
    req_ack   = ack_too;
    @(negedge clk);
    br_taken = 1'b0;
    req_ack  = 1'b0;
    if (ack_too && mq.size() != 0) void'(mq.pop_front());
    mq.push_back(t);
    exp_col = exp_col + CW'(1);
    #1;
  endtask

  task automatic do_ack();
    @(negedge clk);
    req_ack = 1'b1;
    @(negedge clk);
    req_ack = 1'b0;
    void'(mq.pop_front());
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    br_taken = 1'b0; br_target = '0; req_ack = 1'b0;
    in_valid = 1'b0; in_colour = '0; in_pc = '0; in_insn = '0; out_ready = 1'b0;
    exp_col = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check("R1", "req_valid", int'(req_valid), 0);
    drive_pkt(0, 1'b1, 1'b1);
    check("R1", "out_valid colour0", int'(out_valid), 1);
    sweep();

    // R4 R5 R6 R8: single branches through every colour, wrapping once
    for (int k = 0; k < 5; k++) begin
      do_branch(AW'(8'h10 + k), 1'b0);
      check_req("R5");
      for (int h = 0; h < 2; h++) begin
        @(negedge clk); #1;
        check_req("R6");
      end
      // R4: stale packets of any count are consumed and dropped
      for (int n = 0; n < k + 2; n++) begin
        drive_pkt(int'(exp_col - CW'(1)), 1'b1, 1'b0);
        check("R4", "stale out_valid", int'(out_valid), 0);
        check("R4", "stale in_ready", int'(in_ready), 1);
      end
      drive_pkt(int'(exp_col), 1'b1, 1'b1);
      check("R4", "new colour out_valid", int'(out_valid), 1);
      sweep();
      if (k == 3) begin
        // R8: four branches bring the colour back to 0
        drive_pkt(0, 1'b1, 1'b1);
        check("R8", "wrapped colour0 passes", int'(out_valid), 1);
      end
      do_ack();
      check_req("R6");
    end

    // R7: full queue drained oldest first
    do_branch(8'hA1, 1'b0);
    check_req("R7");
    do_branch(8'hB2, 1'b0);
    check_req("R7");
    do_branch(8'hC3, 1'b0);
    check_req("R7");
    sweep();
    for (int a = 0; a < 3; a++) begin
      do_ack();
      check_req("R7");
    end

    // R7: branch and acknowledge in the same cycle
    do_branch(8'hD4, 1'b0);
    check_req("R7");
    do_branch(8'hE5, 1'b1);
    check_req("R7");
    check("R7", "queue depth after merge", int'(req_valid), 1);
    sweep();
    do_ack();
    check_req("R7");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule